// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a linked list of 16-byte transfer descriptors held in memory. A start pulse hands it the address of the first descriptor. The walker reads that descriptor one 32-bit word at a time through a simple read port. It then presents one transfer request per descriptor, giving the buffer address, the length in 8-byte units, the direction, the ordered flag and the DMA mode. It holds the request until the data mover acknowledges it, and only then moves to the next descriptor.

Descriptors are linked by explicit next pointers, and a flag marks the last one. Descriptors with a zero length are skipped without a request, but the walk still continues past them. A pointer that is not on an 8-byte boundary stops the walk with an error pulse. Data movement and buffering belong to the neighbouring stages.

Descriptor word layout (little-endian, word offset from the descriptor base):
- +0: buffer address.
- +4: length in 8-byte units.
- +8: flags byte, with ordered at bit 4, write-to-drive at bit 5 and last-descriptor at bit 7. Bits 11:8 hold the DMA mode. The other bits are don't-care.
- +12: next descriptor pointer.

Top module: `prd_walker`

## Requirements
- R1: After reset, `busy`, `rd_req`, `xfer_req`, `chain_done` and `chain_err` are all low.
- R2: For each descriptor, the walker reads exactly the four words at base+0, +4, +8 and +12, in that order. Each read is held on `rd_req`/`rd_addr` until `rd_valid` returns it.
- R3: While `xfer_req` is high, the request fields are driven from the descriptor words:
  - `xfer_addr` is word +0.
  - `xfer_len` is word +4, unchanged.
  - `xfer_ordered` is bit 4 of word +8.
  - `xfer_write` is bit 5 of word +8.
  - `xfer_mode` is bits 11:8 of word +8.
- R4: Once raised, `xfer_req` stays high with stable fields until `xfer_done`. No descriptor read is issued while a request is pending.
- R5: When bit 7 of word +8 is clear, the walker fetches the next descriptor from the address in word +12.
- R6: When bit 7 of word +8 is set, word +12 is never read as a pointer. `chain_done` pulses for one cycle, in the cycle after the `xfer_done` that acknowledges that descriptor's transfer.
- R7: A descriptor whose length word is zero raises no `xfer_req`. The walk continues to its successor, or completes if the descriptor is the last one.
- R8: A start address with bits 2:0 not zero causes no read. `chain_err` pulses in the cycle after the start.
- R9: A next pointer with bits 2:0 not zero, on a descriptor that is not the last, ends the walk with a one-cycle `chain_err`. No further read is issued.
- R10: A start pulse while `busy` is high is ignored.
- R11: `busy` is high from the cycle after an accepted start until the cycle in which `chain_done` or `chain_err` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `list_addr` |
| list_addr | input | ADDR_W | Address of the first descriptor |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid, completes the pending read |
| rd_data | input | 32 | Read data word |
| xfer_req | output | 1 | Transfer request for the current segment |
| xfer_addr | output | ADDR_W | Segment buffer address |
| xfer_len | output | LEN_W | Segment length in 8-byte units |
| xfer_write | output | 1 | Segment moves data toward the drive |
| xfer_ordered | output | 1 | Ordered flag of the segment |
| xfer_mode | output | 4 | DMA mode of the segment |
| xfer_done | input | 1 | Transfer acknowledged |
| chain_done | output | 1 | One-cycle pulse: chain finished |
| chain_err | output | 1 | One-cycle pulse: misaligned pointer |
| busy | output | 1 | Walk in progress |

## Verification
The bench builds the walker with its default widths, a 32-bit address and a 32-bit length. With these widths, a length of all ones and buffer addresses with their top bits set pass straight through to the request fields.

Descriptor chains are placed at 16-byte slots of a modelled memory that answers reads after a random latency. This lets chains revisit low addresses in any order and bring in misaligned next pointers. The length-width slice used for the zero test covers the whole word, so a length with only its top bit set still counts as non-zero.

// File: rtl/prdw_pkg.sv
package prdw_pkg;
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_FETCH  = 2'd1,
        WS_DECIDE = 2'd2,
        WS_XFER   = 2'd3
    } walk_st_e;

    localparam int DESC_WORDS = 4;
    localparam int WORD_W     = 32;
    localparam int MODE_W     = 4;
    localparam int ALIGN_BITS = 3;
    localparam int FLG_ORD    = 4;
    localparam int FLG_DIR    = 5;
    localparam int FLG_LAST   = 7;
    localparam int MODE_LSB   = 8;
endpackage

// File: rtl/prdw_fetch.sv
module prdw_fetch
    import prdw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [ADDR_W-1:0]    launch_ptr,
    input  logic                 rd_valid,
    input  logic [WORD_W-1:0]    rd_data,
    output logic                 rd_req,
    output logic [ADDR_W-1:0]    rd_addr,
    output logic                 fetch_done,
    output logic [ADDR_W-1:0]    d_addr,
    output logic [LEN_W-1:0]     d_len,
    output logic                 d_ord,
    output logic                 d_dir,
    output logic                 d_last,
    output logic [MODE_W-1:0]    d_mode,
    output logic [ADDR_W-1:0]    d_next
);
    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  widx;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              ord;
        logic              dir;
        logic              last;
        logic [MODE_W-1:0] mode;
        logic [ADDR_W-1:0] nxt;
    } fetch_s;

    fetch_s cur_q, nxt_d;
    logic   done_d;

    always_comb begin
        nxt_d  = cur_q;
        done_d = 1'b0;
        if (launch) begin
            nxt_d.active = 1'b1;
            nxt_d.widx   = '0;
            nxt_d.base   = launch_ptr;
        end else if (cur_q.active && rd_valid) begin
            case (cur_q.widx)
                2'd0: nxt_d.addr = rd_data[ADDR_W-1:0];
                2'd1: nxt_d.len  = rd_data[LEN_W-1:0];
                2'd2: begin
                    nxt_d.ord  = rd_data[FLG_ORD];
                    nxt_d.dir  = rd_data[FLG_DIR];
                    nxt_d.last = rd_data[FLG_LAST];
                    nxt_d.mode = rd_data[MODE_LSB +: MODE_W];
                end
                default: nxt_d.nxt = rd_data[ADDR_W-1:0];
            endcase
            if (cur_q.widx == LAST_IDX) begin
                nxt_d.active = 1'b0;
                done_d       = 1'b1;
            end else begin
                nxt_d.widx = cur_q.widx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_req     = cur_q.active;
    assign rd_addr    = cur_q.base + ADDR_W'({cur_q.widx, 2'b00});
    assign fetch_done = done_d;
    assign d_addr     = cur_q.addr;
    assign d_len      = cur_q.len;
    assign d_ord      = cur_q.ord;
    assign d_dir      = cur_q.dir;
    assign d_last     = cur_q.last;
    assign d_mode     = cur_q.mode;
    assign d_next     = cur_q.nxt;

    AST_FETCH_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && cur_q.widx == '0) |-> (rd_addr[ALIGN_BITS-1:0] == '0)); // R2
    AST_NO_RELAUNCH_MIDFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !rd_req); // R4
    AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R2
endmodule

// File: rtl/prdw_seq.sv
module prdw_seq
    import prdw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] list_addr,
    input  logic              fetch_done,
    input  logic [LEN_W-1:0]  d_len,
    input  logic              d_last,
    input  logic [ADDR_W-1:0] d_next,
    input  logic              xfer_done,
    output logic              launch,
    output logic [ADDR_W-1:0] launch_ptr,
    output logic              xfer_req,
    output logic              chain_done,
    output logic              chain_err,
    output logic              busy
);
    typedef struct packed {
        walk_st_e st;
        logic     done;
        logic     err;
    } seq_s;

    seq_s cur_q, nxt_d;
    logic advance;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.err  = 1'b0;
        launch     = 1'b0;
        launch_ptr = list_addr;
        advance    = 1'b0;
        case (cur_q.st)
            WS_IDLE: begin
                if (start) begin
                    if (list_addr[ALIGN_BITS-1:0] != '0) begin
                        nxt_d.err = 1'b1;
                    end else begin
                        launch   = 1'b1;
                        nxt_d.st = WS_FETCH;
                    end
                end
            end
            WS_FETCH: begin
                if (fetch_done) nxt_d.st = WS_DECIDE;
            end
            WS_DECIDE: begin
                if (d_len != '0) nxt_d.st = WS_XFER;
                else             advance  = 1'b1;
            end
            default: begin
                if (xfer_done) advance = 1'b1;
            end
        endcase
        if (advance) begin
            if (d_last) begin
                nxt_d.done = 1'b1;
                nxt_d.st   = WS_IDLE;
            end else if (d_next[ALIGN_BITS-1:0] != '0) begin
                nxt_d.err = 1'b1;
                nxt_d.st  = WS_IDLE;
            end else begin
                launch     = 1'b1;
                launch_ptr = d_next;
                nxt_d.st   = WS_FETCH;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: WS_IDLE, done: 1'b0, err: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign xfer_req   = (cur_q.st == WS_XFER);
    assign chain_done = cur_q.done;
    assign chain_err  = cur_q.err;
    assign busy       = (cur_q.st != WS_IDLE);

    AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(chain_done && chain_err)); // R6
    AST_DONE_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> ($past(busy) && !busy)); // R11
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> xfer_req); // R4
    AST_ERR_FROM_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_err && !$past(busy)) |-> $past(start && list_addr[ALIGN_BITS-1:0] != '0)); // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> !chain_done); // R6
endmodule

// File: rtl/prd_walker.sv
module prd_walker
    import prdw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] list_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [31:0]       rd_data,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_write,
    output logic              xfer_ordered,
    output logic [3:0]        xfer_mode,
    input  logic              xfer_done,
    output logic              chain_done,
    output logic              chain_err,
    output logic              busy
);
    logic              launch;
    logic [ADDR_W-1:0] launch_ptr;
    logic              fetch_done;
    logic              d_last;
    logic [ADDR_W-1:0] d_next;

    prdw_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .launch_ptr (launch_ptr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .fetch_done (fetch_done),
        .d_addr     (xfer_addr),
        .d_len      (xfer_len),
        .d_ord      (xfer_ordered),
        .d_dir      (xfer_write),
        .d_last     (d_last),
        .d_mode     (xfer_mode),
        .d_next     (d_next)
    );

    prdw_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .list_addr  (list_addr),
        .fetch_done (fetch_done),
        .d_len      (xfer_len),
        .d_last     (d_last),
        .d_next     (d_next),
        .xfer_done  (xfer_done),
        .launch     (launch),
        .launch_ptr (launch_ptr),
        .xfer_req   (xfer_req),
        .chain_done (chain_done),
        .chain_err  (chain_err),
        .busy       (busy)
    );

    AST_NONZERO_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (xfer_len != '0)); // R7
    AST_NO_READ_DURING_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !rd_req); // R4
    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> ($stable(xfer_addr) && $stable(xfer_len) && $stable(xfer_mode))); // R4
    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy); // R11
endmodule

// File: tb/prd_walker_bench.sv
module prd_walker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] list_addr = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        xfer_req;
    logic [31:0] xfer_addr;
    logic [31:0] xfer_len;
    logic        xfer_write;
    logic        xfer_ordered;
    logic [3:0]  xfer_mode;
    logic        xfer_done = 1'b0;
    logic        chain_done;
    logic        chain_err;
    logic        busy;

    int total = 0;
    int bad = 0;

    logic [31:0] mem [0:255];
    logic [31:0] rlog [0:127];
    int nlog = 0;

    logic [31:0] e_addr [0:31];
    logic [31:0] e_len  [0:31];
    logic        e_ord  [0:31];
    logic        e_dir  [0:31];
    logic [3:0]  e_mode [0:31];
    int          e_n;
    logic [31:0] e_rd [0:127];
    int          e_nr;
    int          e_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    prd_walker u_prd_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .list_addr(list_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_write(xfer_write), .xfer_ordered(xfer_ordered), .xfer_mode(xfer_mode),
        .xfer_done(xfer_done), .chain_done(chain_done), .chain_err(chain_err), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] a, input logic [31:0] len,
                            input logic ord, input logic dir, input logic last,
                            input logic [3:0] mode, input logic [31:0] nxt);
        logic [3:0] junk;
        junk = 4'($urandom);
        mem[at[9:2]]       = a;
        mem[at[9:2] + 8'd1] = len;
        mem[at[9:2] + 8'd2] = {8'($urandom), 8'h00, 4'h0, mode, last, 1'b0, dir, ord, junk};
        mem[at[9:2] + 8'd3] = nxt;
    endtask

    // reference walk from the requirements
    task automatic model_walk(input logic [31:0] base);
        logic [31:0] p;
        logic [31:0] w2;
        e_n = 0; e_nr = 0;
        p = base;
        if (base[2:0] != 3'd0) begin
            e_out = 2;
            return;
        end
        for (int k = 0; k < 32; k++) begin
            for (int j = 0; j < 4; j++) e_rd[e_nr + j] = p + 32'(4 * j);
            e_nr += 4;
            w2 = mem[p[9:2] + 8'd2];
            if (mem[p[9:2] + 8'd1] != 32'd0) begin
                e_addr[e_n] = mem[p[9:2]];
                e_len[e_n]  = mem[p[9:2] + 8'd1];
                e_ord[e_n]  = w2[4];
                e_dir[e_n]  = w2[5];
                e_mode[e_n] = w2[11:8];
                e_n++;
            end
            if (w2[7]) begin e_out = 1; return; end
            if (mem[p[9:2] + 8'd3][2:0] != 3'd0) begin e_out = 2; return; end
            p = mem[p[9:2] + 8'd3];
        end
        e_out = 0;
    endtask

    // memory responder with random latency
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req && !rd_valid) begin
                if (nlog < 128) rlog[nlog] = rd_addr;
                nlog++;
                repeat ($urandom % 3) @(negedge clk);
                rd_data  = mem[rd_addr[9:2]];
                rd_valid = 1'b1;
                @(negedge clk);
                rd_valid = 1'b0;
            end
        end
    end

    task automatic run_chain(input logic [31:0] base, input bit inject);
        int seg;
        int outc;
        bit held_ok;
        model_walk(base);
        nlog = 0; seg = 0; outc = 0;
        @(negedge clk);
        start = 1'b1; list_addr = base;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            xfer_done = 1'b0;
            start = 1'b0;
            if (chain_done || chain_err) begin
                outc = chain_done ? 1 : 2;
                break;
            end
            if (c == 0) chk(busy == 1'b1, "R11 busy after start", 32'(busy), 32'd1);
            if (inject && c == 3) begin
                start = 1'b1; list_addr = 32'h0000_0008;
            end
            if (xfer_req) begin
                if (seg < e_n) begin
                    chk(xfer_addr == e_addr[seg], "R3 addr", xfer_addr, e_addr[seg]);
                    chk(xfer_len == e_len[seg], "R3 len", xfer_len, e_len[seg]);
                    chk({xfer_ordered, xfer_write, xfer_mode} == {e_ord[seg], e_dir[seg], e_mode[seg]},
                        "R3 flags/mode", 32'({xfer_ordered, xfer_write, xfer_mode}),
                        32'({e_ord[seg], e_dir[seg], e_mode[seg]}));
                end else begin
                    chk(1'b0, "R7 unexpected request", 32'(seg), 32'(e_n));
                end
                held_ok = 1'b1;
                repeat ($urandom % 4) begin
                    @(negedge clk);
                    if (!xfer_req || rd_req) held_ok = 1'b0;
                end
                chk(held_ok, "R4 request held without reads", 32'(held_ok), 32'd1);
                xfer_done = 1'b1;
                seg++;
            end
            @(negedge clk);
        end
        xfer_done = 1'b0;
        chk(outc == e_out, e_out == 2 ? "R9/R8 error outcome" : "R6 completion outcome", 32'(outc), 32'(e_out));
        chk(seg == e_n, "R7 request count", 32'(seg), 32'(e_n));
        chk(nlog == e_nr, "R2/R5 read count", 32'(nlog), 32'(e_nr));
        for (int j = 0; j < e_nr && j < nlog && j < 128; j++)
            if (rlog[j] != e_rd[j]) chk(1'b0, "R2/R5 read address", rlog[j], e_rd[j]);
        chk(busy == 1'b0, "R11 idle at end", 32'(busy), 32'd0);
        @(negedge clk);
        chk(!chain_done && !chain_err, "R6 single-cycle pulse", 32'({chain_done, chain_err}), 32'd0);
    endtask

    task automatic build_random(output logic [31:0] base);
        int n;
        int s0;
        logic [31:0] at;
        logic [31:0] nx;
        bit corrupt;
        n = 1 + int'($urandom % 5);
        s0 = int'($urandom % 32);
        corrupt = ($urandom % 6) == 0;
        base = 32'((s0 % 32) * 16);
        for (int i = 0; i < n; i++) begin
            at = 32'(((s0 + i * 5) % 32) * 16);
            if (i == n - 1) nx = ($urandom % 2) ? 32'd0 : 32'((($urandom % 32)) * 16);
            else            nx = 32'(((s0 + (i + 1) * 5) % 32) * 16);
            if (corrupt && i == 0 && n > 1) nx = nx | 32'(1 + $urandom % 7);
            put_desc(at, $urandom, (($urandom % 4) == 0) ? 32'd0 : $urandom,
                     1'($urandom), 1'($urandom), i == n - 1, 4'($urandom), nx);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] b;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, rd_req, xfer_req, chain_done, chain_err} == 5'd0, "R1 reset outputs",
            32'({busy, rd_req, xfer_req, chain_done, chain_err}), 32'd0);

        // R6 single last descriptor
        put_desc(32'h40, 32'h8000_1000, 32'd5, 1'b1, 1'b0, 1'b1, 4'h6, 32'd0);
        run_chain(32'h40, 1'b0);

        // R7 zero-length middle and zero-length last
        put_desc(32'h80, 32'h1111_0000, 32'd0, 1'b0, 1'b1, 1'b0, 4'h1, 32'hC0);
        put_desc(32'hC0, 32'h2222_0000, 32'd9, 1'b0, 1'b1, 1'b0, 4'h2, 32'h100);
        put_desc(32'h100, 32'h3333_0000, 32'd0, 1'b1, 1'b1, 1'b1, 4'h3, 32'd0);
        run_chain(32'h80, 1'b0);

        // R8 misaligned start
        run_chain(32'h44, 1'b0);

        // R9 misaligned next on non-last
        put_desc(32'h140, 32'h4444_0000, 32'd3, 1'b0, 1'b0, 1'b0, 4'h4, 32'h183);
        run_chain(32'h140, 1'b0);

        // R6 last descriptor with aligned junk next: not followed
        put_desc(32'h1C0, 32'h5555_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 4'hF, 32'h40);
        run_chain(32'h1C0, 1'b0);

        // R10 start while busy ignored; R5 chain of three
        put_desc(32'h00, 32'hA000_0000, 32'd1, 1'b0, 1'b0, 1'b0, 4'h0, 32'h20);
        put_desc(32'h20, 32'hB000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 4'h7, 32'h60);
        put_desc(32'h60, 32'hC000_0000, 32'd2, 1'b0, 1'b1, 1'b1, 4'h9, 32'd0);
        run_chain(32'h00, 1'b1);

        for (int t = 0; t < 40; t++) begin
            build_random(b);
            run_chain(b, t % 4 == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule